// File: doc/BRIEF.md
# I2C Shared-Address ID Enumeration Slave

This block sits on a two-wire I2C bus as a listen-mostly slave. It lets a master discover every device on the bus without giving each one its own address. All devices answer the same two reserved addresses. A write to the arm address puts every listening device into enumeration mode. A read from the fetch address makes every armed device shift out its fixed 16-bit identifier at the same moment. Because the bus is open-drain, a low bit overrides a high one. A device that lets the line float high but then sees it low has lost the contest, and it goes quiet for the rest of that read.

The device that puts out its whole identifier without losing disarms itself. The next fetch therefore yields the next identifier. Each fetch returns the numerically lowest identifier still armed. A device that is not armed still acknowledges the fetch address but keeps the line released. Once all devices are done, the master reads 0xFFFF and knows enumeration is complete. The identifiers must be distinct and must not be all ones.

The block samples SCL and SDA with its own fast clock. It never stretches the clock, and it exposes one open-drain pull-down output.

Top module: `idenum_slave`

## Requirements
- R1: After reset or at any later time, a write transaction whose first byte is {ARM_ADDR, 1'b0} (7-bit address followed by R/W bit 0) is acknowledged (SDA low on the ninth clock) and arms the device. A later arm write re-arms devices that have already been read out.
- R2: A read transaction whose first byte is {FETCH_ADDR, 1'b1} is acknowledged. An armed device then sends its ID most significant bit first, eight bits per byte, two bytes with a master acknowledge slot between them. SDA is pulled low only when the current bit is 0, and a new pull-down starts only while SCL is low.
- R3: A device that released SDA for a 1 bit and samples SDA low at the SCL rising edge stops pulling SDA low for the rest of that read.
- R4: A device that reaches the rising edge of the last ID bit without losing disarms itself. A device that lost keeps its armed state.
- R5: After one arm write, consecutive fetch reads return the IDs of all armed devices once each, lowest value first.
- R6: An unarmed device acknowledges the fetch address but keeps SDA released for all data bits, so with no armed device the master reads 0xFFFF.
- R7: If the master does not acknowledge the first ID byte, the device sends nothing more in that read and stays armed.
- R8: A STOP or a repeated START during or after a read ends the transaction, releases SDA and clears the arbitration state, leaving the armed state as it was.
- R9: Any other address byte, including the arm address with R/W bit 1, is not acknowledged. Data bytes written after the arm address are not acknowledged either.
- R10: While reset is asserted and after it is released, SDA is released and the device is not armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus (wired-AND result) |
| sda_pull_o | output | 1 | 1 drives SDA low, 0 releases it |

## Verification
On every cycle, the assertions check four rules: a pull-down only begins after SCL was low, a device out of the contest never pulls SDA, the armed state is set only by an acknowledged arm write and cleared only by an uncontested read, and a STOP always lands in idle with SDA released and the armed state kept. Other behaviours only a bench with several devices on one wired-AND line can show. These are the collective outcome of arbitration: the lowest ID winning, each ID appearing exactly once across fetches, the 0xFFFF terminator, and recovery after an aborted read or a repeated START.

// File: rtl/idenum_pkg.sv
package idenum_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } enum_st_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_ev_t;

endpackage

// File: rtl/idenum_bus_mon.sv
module idenum_bus_mon
  import idenum_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_i,
  input  logic    sda_i,
  output logic    scl_s,
  output logic    sda_s,
  output bus_ev_t ev
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] scl_sh_q, sda_sh_q;
  logic [LAST:0] scl_sh_d, sda_sh_d;
  logic          scl_p_q, sda_p_q;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      assign scl_sh_d = {scl_sh_q[LAST-1:0], scl_i};
      assign sda_sh_d = {sda_sh_q[LAST-1:0], sda_i};
    end else begin : g_single
      assign scl_sh_d = scl_i;
      assign sda_sh_d = sda_i;
    end
  endgenerate

  // idle bus level is high on both wires
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q <= '1;
      sda_sh_q <= '1;
      scl_p_q  <= 1'b1;
      sda_p_q  <= 1'b1;
    end else begin
      scl_sh_q <= scl_sh_d;
      sda_sh_q <= sda_sh_d;
      scl_p_q  <= scl_sh_q[LAST];
      sda_p_q  <= sda_sh_q[LAST];
    end
  end

  assign scl_s = scl_sh_q[LAST];
  assign sda_s = sda_sh_q[LAST];

  always_comb begin
    ev.start = scl_s & scl_p_q & sda_p_q & ~sda_s;
    ev.stop  = scl_s & scl_p_q & ~sda_p_q & sda_s;
    ev.rise  = scl_s & ~scl_p_q;
    ev.fall  = ~scl_s & scl_p_q;
  end

endmodule

// File: rtl/idenum_addr_rx.sv
module idenum_addr_rx #(
  parameter int              ADDR_W     = 7,
  parameter logic [ADDR_W-1:0] ARM_ADDR   = 7'h3A,
  parameter logic [ADDR_W-1:0] FETCH_ADDR = 7'h3B
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic sda_s,
  output logic hit_arm,
  output logic hit_fetch
);

  localparam int HDR_W = ADDR_W + 1;
  localparam logic [HDR_W-1:0] ARM_HDR   = {ARM_ADDR, 1'b0};
  localparam logic [HDR_W-1:0] FETCH_HDR = {FETCH_ADDR, 1'b1};

  logic [HDR_W-1:0] hdr_q, hdr_d;

  always_comb begin
    hdr_d = hdr_q;
    if (shift_en) hdr_d = {hdr_q[HDR_W-2:0], sda_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hdr_q <= '0;
    else        hdr_q <= hdr_d;
  end

  assign hit_arm   = (hdr_q == ARM_HDR);
  assign hit_fetch = (hdr_q == FETCH_HDR);

endmodule

// File: rtl/idenum_id_tx.sv
module idenum_id_tx #(
  parameter int            ID_W   = 16,
  parameter logic [ID_W-1:0] DEV_ID = 16'h0001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic shift,
  output logic cur_bit,
  output logic nxt_bit
);

  logic [ID_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load)       sh_d = DEV_ID;
    else if (shift) sh_d = {sh_q[ID_W-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign cur_bit = sh_q[ID_W-1];
  assign nxt_bit = sh_q[ID_W-2];

endmodule

// File: rtl/idenum_arb.sv
module idenum_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  logic arm,
  input  logic sample,
  input  logic last,
  input  logic sent_one,
  input  logic sda_s,
  output logic contend,
  output logic win
);

  logic contend_q, contend_d;
  logic overridden;

  assign overridden = sent_one & ~sda_s;

  always_comb begin
    contend_d = contend_q;
    if (clr)                              contend_d = 1'b0;
    else if (load)                        contend_d = arm;
    else if (sample && overridden)        contend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) contend_q <= 1'b0;
    else        contend_q <= contend_d;
  end

  assign contend = contend_q;
  assign win     = sample & last & contend_q & ~overridden;

endmodule

// File: rtl/idenum_slave.sv
module idenum_slave
  import idenum_pkg::*;
#(
  parameter int                ADDR_W      = 7,
  parameter logic [ADDR_W-1:0] ARM_ADDR    = 7'h3A,
  parameter logic [ADDR_W-1:0] FETCH_ADDR  = 7'h3B,
  parameter int                ID_W        = 16,
  parameter logic [ID_W-1:0]   DEV_ID      = 16'h0001,
  parameter int                SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);

  localparam int              NBYTES    = ID_W / 8;
  localparam int              BYTE_W    = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(NBYTES - 1);
  localparam logic            ID_MSB    = DEV_ID[ID_W-1];
  localparam logic [3:0]      BIT_END   = 4'd8;

  logic    scl_s, sda_s;
  bus_ev_t ev;

  enum_st_e          st_q, st_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              active_q, active_d;
  logic              pull_q, pull_d;
  logic              is_arm_q, is_arm_d;
  logic              mack_q, mack_d;

  logic addr_shift, hit_arm, hit_fetch;
  logic tx_load, tx_shift, cur_bit, nxt_bit;
  logic arb_clr, arb_load, arb_sample, arb_last, contend, win;

  idenum_bus_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .scl_s (scl_s),
    .sda_s (sda_s),
    .ev    (ev)
  );

  idenum_addr_rx #(
    .ADDR_W     (ADDR_W),
    .ARM_ADDR   (ARM_ADDR),
    .FETCH_ADDR (FETCH_ADDR)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (addr_shift),
    .sda_s     (sda_s),
    .hit_arm   (hit_arm),
    .hit_fetch (hit_fetch)
  );

  idenum_id_tx #(.ID_W(ID_W), .DEV_ID(DEV_ID)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tx_load),
    .shift   (tx_shift),
    .cur_bit (cur_bit),
    .nxt_bit (nxt_bit)
  );

  assign arb_last = (byte_q == LAST_BYTE) && (cnt_q == 4'd7);

  idenum_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (arb_clr),
    .load     (arb_load),
    .arm      (active_q),
    .sample   (arb_sample),
    .last     (arb_last),
    .sent_one (cur_bit),
    .sda_s    (sda_s),
    .contend  (contend),
    .win      (win)
  );

  // next-state logic
  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    byte_d     = byte_q;
    active_d   = active_q;
    pull_d     = pull_q;
    is_arm_d   = is_arm_q;
    mack_d     = mack_q;
    addr_shift = 1'b0;
    tx_load    = 1'b0;
    tx_shift   = 1'b0;
    arb_clr    = 1'b0;
    arb_load   = 1'b0;
    arb_sample = 1'b0;

    if (ev.stop) begin
      st_d    = ST_IDLE;
      pull_d  = 1'b0;
      arb_clr = 1'b1;
    end else if (ev.start) begin
      st_d    = ST_ADDR;
      cnt_d   = '0;
      pull_d  = 1'b0;
      arb_clr = 1'b1;
    end else begin
      unique case (st_q)
        ST_ADDR: begin
          if (ev.rise) begin
            addr_shift = 1'b1;
            cnt_d      = cnt_q + 4'd1;
          end else if (ev.fall && cnt_q == BIT_END) begin
            if (hit_arm || hit_fetch) begin
              st_d     = ST_AACK;
              pull_d   = 1'b1;
              is_arm_d = hit_arm;
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        ST_AACK: begin
          if (ev.fall) begin
            if (is_arm_q) begin
              active_d = 1'b1;
              pull_d   = 1'b0;
              st_d     = ST_SKIP;
            end else begin
              st_d     = ST_TX;
              cnt_d    = '0;
              byte_d   = '0;
              tx_load  = 1'b1;
              arb_load = 1'b1;
              pull_d   = active_q & ~ID_MSB;
            end
          end
        end
        ST_TX: begin
          if (ev.rise) begin
            arb_sample = 1'b1;
            cnt_d      = cnt_q + 4'd1;
            if (win) active_d = 1'b0;
          end else if (ev.fall) begin
            if (cnt_q == BIT_END) begin
              pull_d = 1'b0;
              st_d   = ST_MACK;
            end else begin
              tx_shift = 1'b1;
              pull_d   = contend & ~nxt_bit;
            end
          end
        end
        ST_MACK: begin
          if (ev.rise) begin
            mack_d = ~sda_s;
          end else if (ev.fall) begin
            if (mack_q && byte_q != LAST_BYTE) begin
              byte_d   = byte_q + 1'b1;
              cnt_d    = '0;
              st_d     = ST_TX;
              tx_shift = 1'b1;
              pull_d   = contend & ~nxt_bit;
            end else begin
              st_d   = ST_SKIP;
              pull_d = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      byte_q   <= '0;
      active_q <= 1'b0;
      pull_q   <= 1'b0;
      is_arm_q <= 1'b0;
      mack_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      byte_q   <= byte_d;
      active_q <= active_d;
      pull_q   <= pull_d;
      is_arm_q <= is_arm_d;
      mack_q   <= mack_d;
    end
  end

  assign sda_pull_o = pull_q;

  // R2
  pull_starts_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> !$past(scl_s));

  // R3
  out_of_contest_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TX && !contend) |-> !pull_q);

  // R4
  disarm_by_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> $past(st_q == ST_TX && contend));

  // R1
  arm_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(st_q == ST_AACK && is_arm_q));

  // R8
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev.stop) |-> (st_q == ST_IDLE && !pull_q && active_q == $past(active_q)));

endmodule

// File: tb/idenum_slave_tb.sv
`timescale 1ns/1ps
module idenum_slave_tb_top;

  localparam int H = 8;
  localparam logic [6:0] ARM   = 7'h3A;
  localparam logic [6:0] FETCH = 7'h3B;
  localparam logic [15:0] ID_A = 16'h5A3C;
  localparam logic [15:0] ID_B = 16'h1234;
  localparam logic [15:0] ID_C = 16'h5A31;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic m_scl, m_sda;
  logic [2:0] pull;
  logic bus_sda;

  assign bus_sda = m_sda & ~(|pull);

  idenum_slave #(.ARM_ADDR(ARM), .FETCH_ADDR(FETCH), .DEV_ID(ID_A)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda), .sda_pull_o(pull[0]));
  idenum_slave #(.ARM_ADDR(ARM), .FETCH_ADDR(FETCH), .DEV_ID(ID_B)) dut1_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda), .sda_pull_o(pull[1]));
  idenum_slave #(.ARM_ADDR(ARM), .FETCH_ADDR(FETCH), .DEV_ID(ID_C)) dut2_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda), .sda_pull_o(pull[2]));

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model: pool of armed identifiers
  int unsigned pool[$];

  function automatic void model_arm();
    pool = {};
    pool.push_back(ID_A);
    pool.push_back(ID_B);
    pool.push_back(ID_C);
  endfunction

  function automatic logic [15:0] model_next();
    int unsigned best = 32'hFFFF;
    foreach (pool[i]) if (pool[i] < best) best = pool[i];
    return best[15:0];
  endfunction

  function automatic void model_take(input logic [15:0] v);
    for (int i = 0; i < pool.size(); i++)
      if (pool[i] == v) begin pool.delete(i); break; end
  endfunction

  // per-clock comparison of the wired line against the model's bit
  logic  chk_en = 1'b0;
  logic  exp_bit = 1'b1;
  string cur_req = "R2";

  always @(negedge clk) begin
    if (chk_en && rst_n) begin
      checks++;
      if (bus_sda !== exp_bit) begin
        failures++;
        $display("FAIL %s bus bit actual=%b expected=%b t=%0t", cur_req, bus_sda, exp_bit, $time);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic drive, input logic do_chk, input logic eb,
                         input string req, output logic sampled);
    m_sda = drive;
    wait_clk(H);
    m_scl   = 1'b1;
    exp_bit = eb;
    cur_req = req;
    chk_en  = do_chk;
    wait_clk(H/2);
    sampled = bus_sda;
    wait_clk(H/2);
    chk_en = 1'b0;
    m_scl  = 1'b0;
    wait_clk(2);
  endtask

  task automatic bus_start();
    if (!m_scl) begin
      m_sda = 1'b1;
      wait_clk(H);
      m_scl = 1'b1;
      wait_clk(H);
    end
    m_sda = 1'b0;
    wait_clk(H);
    m_scl = 1'b0;
    wait_clk(2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0;
    wait_clk(H);
    m_scl = 1'b1;
    wait_clk(H);
    m_sda = 1'b1;
    wait_clk(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b0, 1'b1, req, s);
    clk_bit(1'b1, 1'b1, exp_ack, req, s);
    check(s == exp_ack, req, s, exp_ack);
  endtask

  task automatic recv_byte(input logic [7:0] eb, input logic m_ack, input string req,
                           output logic [7:0] got);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, 1'b1, eb[i], req, s);
      got[i] = s;
    end
    clk_bit(~m_ack, 1'b0, 1'b1, req, s);
  endtask

  task automatic fetch_word(input string req, input bit restart);
    logic [15:0] e;
    logic [7:0]  hi, lo;
    e = model_next();
    if (restart) bus_start(); else bus_start();
    send_byte({FETCH, 1'b1}, 1'b0, req);
    recv_byte(e[15:8], 1'b1, req, hi);
    recv_byte(e[7:0], 1'b0, req, lo);
    check({hi, lo} == e, req, {hi, lo}, e);
    if (e != 16'hFFFF) model_take(e);
  endtask

  initial begin
    logic [7:0] tmp;
    logic s;
    rst_n = 1'b0;
    m_scl = 1'b1;
    m_sda = 1'b1;
    wait_clk(5);
    // R10: released during reset
    check(pull == 3'b000, "R10", pull, 0);
    rst_n = 1'b1;
    wait_clk(10);
    check(pull == 3'b000, "R10", pull, 0);

    // R6 and R10: nobody armed after reset, fetch reads all ones
    fetch_word("R6", 0);
    bus_stop();

    // R9: foreign address and arm address with read bit are not acknowledged
    bus_start();
    send_byte({7'h33, 1'b0}, 1'b1, "R9");
    bus_stop();
    bus_start();
    send_byte({ARM, 1'b1}, 1'b1, "R9");
    bus_stop();
    check(pull == 3'b000, "R9", pull, 0);

    // R1: arm write acknowledged; R9: following data byte not acknowledged
    bus_start();
    send_byte({ARM, 1'b0}, 1'b0, "R1");
    send_byte(8'h00, 1'b1, "R9");
    bus_stop();
    model_arm();

    // R2/R5: lowest identifier wins the first fetch
    fetch_word("R5", 0);
    bus_stop();

    // R7: master NACK after first byte leaves the winner armed
    bus_start();
    send_byte({FETCH, 1'b1}, 1'b0, "R7");
    recv_byte(model_next() >> 8, 1'b0, "R7", tmp);
    check(tmp == model_next() >> 8, "R7", tmp, model_next() >> 8);
    bus_stop();
    check(pull == 3'b000, "R7", pull, 0);

    // R8: abort with STOP after four bits (next bit of 0x5A is 1)
    bus_start();
    send_byte({FETCH, 1'b1}, 1'b0, "R8");
    for (int i = 7; i >= 4; i--) clk_bit(1'b1, 1'b1, ID_C[8+i], "R8", s);
    bus_stop();
    check(pull == 3'b000, "R8", pull, 0);

    // R8/R3/R4: aborted read did not disarm; lower-bit arbitration between 5A31 and 5A3C
    fetch_word("R8", 0);
    fetch_word("R3", 1);   // repeated START, no STOP between
    fetch_word("R4", 1);   // all taken: ones
    bus_stop();
    check(pool.size() == 0, "R5", pool.size(), 0);

    // R1: re-arm returns the lowest identifier again
    bus_start();
    send_byte({ARM, 1'b0}, 1'b0, "R1");
    bus_stop();
    model_arm();
    fetch_word("R1", 0);
    bus_stop();
    check(pull == 3'b000, "R2", pull, 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule